// File: doc/BRIEF.md
# DDR Command Spacing Checker

This block is a passive, synchronous monitor placed beside a DDR SDRAM command port. Each clock it may see one command, qualified by a valid strobe and tagged with a bank index. It keeps a small model of every bank: idle, open, or in a data burst with or without auto precharge. It raises a one-cycle violation flag with a reason code whenever the command breaks a sequencing or spacing rule.

The central job is the cross-bank spacing after a read or write with auto precharge. The minimum distance to the next command on another bank depends on both the earlier auto-precharge command and the later command. The read-to-write case uses the CAS latency, given in half cycles and rounded up to whole cycles. The block also checks several bank-state rules: refresh and mode-register load need every bank idle, a burst-stop must hit a bank that is bursting, activates need an idle bank, and column commands need an open bank. A write may not cut into an unfinished read burst unless a burst-stop ended it first. A command that is flagged is treated as never issued, so the bank model keeps following the legal stream.

Command codes are NOP=0, DESELECT=1, ACTIVATE=2, READ=3, READ+AP=4, WRITE=5, WRITE+AP=6, PRECHARGE=7, REFRESH=8, MODE LOAD=9 and BURST STOP=10. Codes 11 to 15 are unknown. In the requirements below, BL is the burst length, H = BL/2, and C is the CAS latency rounded up to a whole number of cycles. A gap of g means a command issued k cycles after the earlier one is flagged when k < g.

Top module: `ddr_cmd_spacing_mon`

## Requirements
- R1: After reset the flag is 0, the reason is 0, and every bank is idle, so a REFRESH is accepted at once.
- R2: NOP, DESELECT, and any cycle with valid low never raise the flag, and a command with valid low leaves the bank model unchanged.
- R3: A command sampled at clock edge t is judged at that edge. The flag and reason are visible from edge t until edge t+1. The reason is 0 exactly when the flag is 0, and a flagged command does not change the bank model.
- R4: A READ or READ+AP to a bank other than the target of an earlier WRITE+AP has a gap of 1 + H + the write-to-read turnaround. A breach gives reason 6.
- R5: A WRITE or WRITE+AP to a bank other than the target of an earlier WRITE+AP has a gap of H. A breach gives reason 7.
- R6: A READ or READ+AP to a bank other than the target of an earlier READ+AP has a gap of H. A breach gives reason 8.
- R7: A WRITE or WRITE+AP to a bank other than the target of an earlier READ+AP has a gap of C + H, where C is the half-cycle CAS latency rounded up. A breach gives reason 9.
- R8: A PRECHARGE or ACTIVATE to another bank is legal from the first cycle after any auto-precharge command.
- R9: REFRESH and MODE LOAD are flagged with reason 1 unless all banks are idle. A bank with an auto-precharge burst issued at cycle t0 becomes idle at cycle t0+H+1.
- R10: A BURST STOP is flagged with reason 2 unless its bank is in a burst without auto precharge. Each burst lasts H cycles after its command. A legal burst stop returns the bank to open and lifts the R11 restriction.
- R11: After a READ without auto precharge, a WRITE or WRITE+AP to any bank within C + H cycles is flagged with reason 5, unless a burst stop came first.
- R12: An ACTIVATE to a bank that is not idle gives reason 3. A column command to a bank that is idle, or that is in an auto-precharge burst, gives reason 4.
- R13: Unknown codes give reason 10. When several rules are broken, reason 4 beats reason 5, and reason 5 beats reasons 6 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Qualifies the command in this cycle |
| cmd_i | input | 4 | Command code |
| bank_i | input | BANK_W | Target bank |
| viol_o | output | 1 | One-cycle violation flag |
| reason_o | output | 4 | Code of the broken rule, 0 when clean |

## Verification
Every cycle, the embedded assertions check several things. Idle commands and unqualified cycles stay quiet. The flag and the reason code agree. Refresh or mode load with a busy bank always comes out as reason 1. Unknown codes come out as reason 10. An accepted auto-precharge command always arms its spacing counters and closes its bank. An accepted plain read always arms the write block. The exact gap lengths, the cycle on which a bank returns to idle, the priority between codes, and the rule that flagged commands leave no trace can only be shown by the bench. It sweeps the distance between commands one cycle at a time for burst lengths 2, 4 and 8 side by side and compares each result with gaps it computes itself.

// File: rtl/ddr_spc_pkg.sv
`timescale 1ns/1ps
package ddr_spc_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_RDA   = 4'd4,
    CMD_WR    = 4'd5,
    CMD_WRA   = 4'd6,
    CMD_PRE   = 4'd7,
    CMD_REF   = 4'd8,
    CMD_LMR   = 4'd9,
    CMD_BST   = 4'd10
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    RSN_OK       = 4'd0,
    RSN_NOT_IDLE = 4'd1,
    RSN_BST_BAD  = 4'd2,
    RSN_ACT_BUSY = 4'd3,
    RSN_NOT_OPEN = 4'd4,
    RSN_RD_OPEN  = 4'd5,
    RSN_WA_RD    = 4'd6,
    RSN_WA_WR    = 4'd7,
    RSN_RA_RD    = 4'd8,
    RSN_RA_WR    = 4'd9,
    RSN_BAD_CMD  = 4'd10
  } rsn_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_BURST = 2'd2
  } bank_mode_e;

  // CAS latency held in half cycles, rounded up to whole cycles
  function automatic int cas_up(input int cas_half);
    return (cas_half + 1) / 2;
  endfunction

  function automatic int half_burst(input int bl);
    return bl / 2;
  endfunction

  function automatic int gap_wa_rd(input int bl, input int wtr);
    return 1 + half_burst(bl) + wtr;
  endfunction

  function automatic int gap_wa_wr(input int bl);
    return half_burst(bl);
  endfunction

  function automatic int gap_ra_rd(input int bl);
    return half_burst(bl);
  endfunction

  function automatic int gap_ra_wr(input int bl, input int cas_half);
    return cas_up(cas_half) + half_burst(bl);
  endfunction

  function automatic int max_gap(input int bl, input int cas_half, input int wtr);
    int m;
    m = gap_wa_rd(bl, wtr);
    if (gap_ra_wr(bl, cas_half) > m) m = gap_ra_wr(bl, cas_half);
    return m;
  endfunction

  function automatic logic is_rd(input logic [3:0] c);
    return (c == CMD_RD) || (c == CMD_RDA);
  endfunction

  function automatic logic is_wr(input logic [3:0] c);
    return (c == CMD_WR) || (c == CMD_WRA);
  endfunction

  function automatic logic is_ap(input logic [3:0] c);
    return (c == CMD_RDA) || (c == CMD_WRA);
  endfunction

endpackage

// File: rtl/ddr_spc_bank.sv
`timescale 1ns/1ps
module ddr_spc_bank
  import ddr_spc_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CAS_HALF  = 5,
  parameter int WR2RD_CYC = 2,
  parameter int GAP_W     = 3,
  parameter int BEAT_W    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply_i,
  input  logic [3:0] cmd_i,
  output logic       idle_o,
  output logic       usable_o,
  output logic       plain_burst_o,
  output logic       rd_gap_busy_o,
  output logic       wr_gap_busy_o,
  output logic       gap_src_wr_o
);

  localparam logic [GAP_W-1:0]  LD_WA_RD = GAP_W'(gap_wa_rd(BURST_LEN, WR2RD_CYC) - 1);
  localparam logic [GAP_W-1:0]  LD_WA_WR = GAP_W'(gap_wa_wr(BURST_LEN) - 1);
  localparam logic [GAP_W-1:0]  LD_RA_RD = GAP_W'(gap_ra_rd(BURST_LEN) - 1);
  localparam logic [GAP_W-1:0]  LD_RA_WR = GAP_W'(gap_ra_wr(BURST_LEN, CAS_HALF) - 1);
  localparam logic [BEAT_W-1:0] BEATS    = BEAT_W'(half_burst(BURST_LEN));
  localparam logic [GAP_W-1:0]  G_ONE    = GAP_W'(1);
  localparam logic [BEAT_W-1:0] B_ONE    = BEAT_W'(1);

  bank_mode_e        mode_q;
  logic              ap_q;
  logic [BEAT_W-1:0] beat_q;
  logic [GAP_W-1:0]  to_rd_q;
  logic [GAP_W-1:0]  to_wr_q;
  logic              src_wr_q;

  // named internal events
  logic burst_last;
  assign burst_last = (mode_q == BK_BURST) && (beat_q == B_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= BK_IDLE;
      ap_q     <= 1'b0;
      beat_q   <= '0;
      to_rd_q  <= '0;
      to_wr_q  <= '0;
      src_wr_q <= 1'b0;
    end else begin
      if (to_rd_q != '0) to_rd_q <= to_rd_q - G_ONE;
      if (to_wr_q != '0) to_wr_q <= to_wr_q - G_ONE;
      if (mode_q == BK_BURST && beat_q != '0) beat_q <= beat_q - B_ONE;
      if (burst_last) begin
        mode_q <= ap_q ? BK_IDLE : BK_OPEN;
        ap_q   <= 1'b0;
      end
      if (apply_i) begin
        case (cmd_i)
          CMD_ACT: begin
            mode_q <= BK_OPEN;
            ap_q   <= 1'b0;
          end
          CMD_RD, CMD_WR, CMD_RDA, CMD_WRA: begin
            mode_q <= BK_BURST;
            beat_q <= BEATS;
            ap_q   <= is_ap(cmd_i);
            if (cmd_i == CMD_RDA) begin
              to_rd_q  <= LD_RA_RD;
              to_wr_q  <= LD_RA_WR;
              src_wr_q <= 1'b0;
            end else if (cmd_i == CMD_WRA) begin
              to_rd_q  <= LD_WA_RD;
              to_wr_q  <= LD_WA_WR;
              src_wr_q <= 1'b1;
            end
          end
          CMD_PRE: begin
            if (!(mode_q == BK_BURST && ap_q)) begin
              mode_q <= BK_IDLE;
              beat_q <= '0;
              ap_q   <= 1'b0;
            end
          end
          CMD_BST: begin
            mode_q <= BK_OPEN;
            beat_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign idle_o        = (mode_q == BK_IDLE);
  assign usable_o      = (mode_q == BK_OPEN) || ((mode_q == BK_BURST) && !ap_q);
  assign plain_burst_o = (mode_q == BK_BURST) && !ap_q;
  assign rd_gap_busy_o = (to_rd_q != '0);
  assign wr_gap_busy_o = (to_wr_q != '0);
  assign gap_src_wr_o  = src_wr_q;

  // R12: an accepted auto-precharge command closes the bank to column commands
  assert_ap_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && is_ap(cmd_i)) |=> (!usable_o && !idle_o))
    else $error("auto-precharge burst left bank usable");

  // R4: write with auto precharge arms the read spacing, marked as write-sourced
  assert_wa_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && cmd_i == CMD_WRA) |=> (rd_gap_busy_o && gap_src_wr_o))
    else $error("write+AP did not arm read spacing");

  // R7: read with auto precharge arms the write spacing, marked as read-sourced
  assert_ra_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && cmd_i == CMD_RDA) |=> (wr_gap_busy_o && !gap_src_wr_o))
    else $error("read+AP did not arm write spacing");

endmodule

// File: rtl/ddr_spc_rule.sv
`timescale 1ns/1ps
module ddr_spc_rule
  import ddr_spc_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic          valid_i,
  input  logic [3:0]    cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic [NB-1:0] idle_v,
  input  logic [NB-1:0] usable_v,
  input  logic [NB-1:0] plain_burst_v,
  input  logic [NB-1:0] rd_gap_v,
  input  logic [NB-1:0] wr_gap_v,
  input  logic [NB-1:0] src_wr_v,
  input  logic          rd_block_i,
  output logic          viol_o,
  output logic [3:0]    reason_o
);

  logic fnd_rd, fnd_wr, src_rd, src_wr;
  logic all_idle;

  assign all_idle = &idle_v;

  // first other bank with a running spacing window, per direction
  always_comb begin
    fnd_rd = 1'b0;
    fnd_wr = 1'b0;
    src_rd = 1'b0;
    src_wr = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (BW'(b) != bank_i && rd_gap_v[b] && !fnd_rd) begin
        fnd_rd = 1'b1;
        src_rd = src_wr_v[b];
      end
      if (BW'(b) != bank_i && wr_gap_v[b] && !fnd_wr) begin
        fnd_wr = 1'b1;
        src_wr = src_wr_v[b];
      end
    end
  end

  always_comb begin
    reason_o = RSN_OK;
    if (valid_i) begin
      case (cmd_i)
        CMD_NOP, CMD_DESEL, CMD_PRE: reason_o = RSN_OK;
        CMD_REF, CMD_LMR: if (!all_idle) reason_o = RSN_NOT_IDLE;
        CMD_BST: if (!plain_burst_v[bank_i]) reason_o = RSN_BST_BAD;
        CMD_ACT: if (!idle_v[bank_i]) reason_o = RSN_ACT_BUSY;
        CMD_RD, CMD_RDA: begin
          if (!usable_v[bank_i])  reason_o = RSN_NOT_OPEN;
          else if (fnd_rd)        reason_o = src_rd ? RSN_WA_RD : RSN_RA_RD;
        end
        CMD_WR, CMD_WRA: begin
          if (!usable_v[bank_i])  reason_o = RSN_NOT_OPEN;
          else if (rd_block_i)    reason_o = RSN_RD_OPEN;
          else if (fnd_wr)        reason_o = src_wr ? RSN_WA_WR : RSN_RA_WR;
        end
        default: reason_o = RSN_BAD_CMD;
      endcase
    end
  end

  assign viol_o = (reason_o != RSN_OK);

endmodule

// File: rtl/ddr_cmd_spacing_mon.sv
`timescale 1ns/1ps
module ddr_cmd_spacing_mon
  import ddr_spc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int CAS_HALF  = 5,
  parameter int WR2RD_CYC = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              viol_o,
  output logic [3:0]        reason_o
);

  localparam int GAP_W  = $clog2(max_gap(BURST_LEN, CAS_HALF, WR2RD_CYC) + 1);
  localparam int BEAT_W = $clog2(half_burst(BURST_LEN) + 1);
  localparam logic [GAP_W-1:0] LD_RDBLK = GAP_W'(gap_ra_wr(BURST_LEN, CAS_HALF) - 1);
  localparam logic [GAP_W-1:0] G_ONE    = GAP_W'(1);

  logic [NUM_BANKS-1:0] idle_v, usable_v, pburst_v, rdgap_v, wrgap_v, srcwr_v;
  logic                 viol_now;
  logic [3:0]           rsn_now;
  logic                 cmd_accept;
  logic [GAP_W-1:0]     rdblk_q;
  logic                 rd_block;

  assign cmd_accept = cmd_valid_i && !viol_now;
  assign rd_block   = (rdblk_q != '0);

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic apply;
    assign apply = cmd_accept && (bank_i == BANK_W'(gb));
    ddr_spc_bank #(
      .BURST_LEN(BURST_LEN), .CAS_HALF(CAS_HALF), .WR2RD_CYC(WR2RD_CYC),
      .GAP_W(GAP_W), .BEAT_W(BEAT_W)
    ) u_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .apply_i       (apply),
      .cmd_i         (cmd_i),
      .idle_o        (idle_v[gb]),
      .usable_o      (usable_v[gb]),
      .plain_burst_o (pburst_v[gb]),
      .rd_gap_busy_o (rdgap_v[gb]),
      .wr_gap_busy_o (wrgap_v[gb]),
      .gap_src_wr_o  (srcwr_v[gb])
    );
  end

  ddr_spc_rule #(.NB(NUM_BANKS), .BW(BANK_W)) u_rule (
    .valid_i       (cmd_valid_i),
    .cmd_i         (cmd_i),
    .bank_i        (bank_i),
    .idle_v        (idle_v),
    .usable_v      (usable_v),
    .plain_burst_v (pburst_v),
    .rd_gap_v      (rdgap_v),
    .wr_gap_v      (wrgap_v),
    .src_wr_v      (srcwr_v),
    .rd_block_i    (rd_block),
    .viol_o        (viol_now),
    .reason_o      (rsn_now)
  );

  // window after a plain read during which writes are refused
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdblk_q <= '0;
    end else if (cmd_accept && cmd_i == CMD_RD) begin
      rdblk_q <= LD_RDBLK;
    end else if (cmd_accept && cmd_i == CMD_BST) begin
      rdblk_q <= '0;
    end else if (rd_block) begin
      rdblk_q <= rdblk_q - G_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o   <= 1'b0;
      reason_o <= RSN_OK;
    end else begin
      viol_o   <= viol_now;
      reason_o <= rsn_now;
    end
  end

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid_i || cmd_i == CMD_NOP || cmd_i == CMD_DESEL) |=> !viol_o)
    else $error("idle cycle raised a violation");

  assert_flag_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o == (reason_o != RSN_OK))
    else $error("flag and reason disagree");

  assert_refresh_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && (cmd_i == CMD_REF || cmd_i == CMD_LMR) && !(&idle_v))
      |=> (viol_o && reason_o == RSN_NOT_IDLE))
    else $error("refresh with busy bank not reported");

  assert_rd_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && cmd_i == CMD_RD) |=> rd_block)
    else $error("plain read did not arm write block");

  assert_bad_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_i > CMD_BST) |=> (reason_o == RSN_BAD_CMD))
    else $error("unknown code not reported");

endmodule

// File: tb/ddr_cmd_spacing_mon_bench.sv
`timescale 1ns/1ps
module ddr_cmd_spacing_mon_bench;
  import ddr_spc_pkg::*;

  localparam int CAS_H = 5;
  localparam int WTR   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic [1:0] bank = 2'd0;
  logic [2:0] viol_w;
  logic [3:0] rsn_w [3];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar gi = 0; gi < 3; gi++) begin : g_bl
    ddr_cmd_spacing_mon #(
      .NUM_BANKS(4), .BURST_LEN(2 << gi), .CAS_HALF(CAS_H), .WR2RD_CYC(WTR)
    ) u_ddr_cmd_spacing_mon (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(v), .cmd_i(cmd), .bank_i(bank),
      .viol_o(viol_w[gi]), .reason_o(rsn_w[gi])
    );
  end

  function automatic int blh(input int i);
    return 1 << i;
  endfunction

  function automatic int clr();
    return CAS_H / 2 + CAS_H % 2;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic put(input logic vv, input logic [3:0] c, input logic [1:0] b);
    @(negedge clk);
    v = vv; cmd = c; bank = b;
    @(posedge clk);
    #1;
  endtask

  task automatic nops(input int n);
    for (int j = 0; j < n; j++) put(1'b1, CMD_NOP, 2'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; v = 1'b0; cmd = CMD_NOP; bank = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk(input int i, input logic ev, input logic [3:0] ec, input string tag);
    total++;
    if (viol_w[i] !== ev || rsn_w[i] !== ec) begin
      bad++;
      $display("FAIL %s bl=%0d: got viol=%0b code=%0d, want viol=%0b code=%0d",
               tag, 2 << i, viol_w[i], rsn_w[i], ev, ec);
    end
  endtask

  task automatic chk_all(input logic ev, input logic [3:0] ec, input string tag);
    for (int i = 0; i < 3; i++) chk(i, ev, ec, tag);
  endtask

  function automatic int gap_of(input int kind, input int i);
    case (kind)
      0:       return blh(i) + 1 + WTR;
      1:       return blh(i);
      2:       return blh(i);
      default: return clr() + blh(i);
    endcase
  endfunction

  function automatic string tag_of(input int kind);
    case (kind)
      0:       return "R4";
      1:       return "R5";
      2:       return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, want completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    @(posedge clk); #1;
    chk_all(1'b0, 4'd0, "R1 reset");
    put(1'b1, CMD_REF, 2'd0);
    chk_all(1'b0, 4'd0, "R1 refresh after reset");

    // R2: unqualified commands leave no trace
    do_reset();
    put(1'b0, CMD_ACT, 2'd0);
    put(1'b0, CMD_ACT, 2'd0);
    chk_all(1'b0, 4'd0, "R2 valid low");
    put(1'b1, CMD_DESEL, 2'd1);
    chk_all(1'b0, 4'd0, "R2 deselect");
    put(1'b1, CMD_NOP, 2'd1);
    chk_all(1'b0, 4'd0, "R2 nop");
    put(1'b1, CMD_REF, 2'd0);
    chk_all(1'b0, 4'd0, "R2 state untouched");

    // R4..R7: sweep follower distance after an auto-precharge command
    for (int kind = 0; kind < 4; kind++) begin
      for (int k = 1; k <= 9; k++) begin
        logic [3:0] lead, foll;
        lead = (kind < 2) ? 4'(CMD_WRA) : 4'(CMD_RDA);
        case (kind)
          0: foll = CMD_RD;
          1: foll = CMD_WRA;
          2: foll = CMD_RDA;
          default: foll = CMD_WR;
        endcase
        do_reset();
        put(1'b1, CMD_ACT, 2'd0);
        put(1'b1, CMD_ACT, 2'd1);
        put(1'b1, lead, 2'd0);
        if (k == 1) chk_all(1'b0, 4'd0, "R3 lead accepted");
        nops(k - 1);
        put(1'b1, foll, 2'd1);
        for (int i = 0; i < 3; i++) begin
          logic ev;
          ev = (k < gap_of(kind, i));
          chk(i, ev, ev ? 4'(6 + kind) : 4'd0, tag_of(kind));
        end
      end
    end

    // R8: precharge and activate to other banks right away
    for (int w = 0; w < 2; w++) begin
      do_reset();
      put(1'b1, CMD_ACT, 2'd0);
      put(1'b1, CMD_ACT, 2'd1);
      put(1'b1, w == 0 ? 4'(CMD_RDA) : 4'(CMD_WRA), 2'd0);
      put(1'b1, CMD_PRE, 2'd1);
      chk_all(1'b0, 4'd0, "R8 precharge");
      put(1'b1, CMD_ACT, 2'd2);
      chk_all(1'b0, 4'd0, "R8 activate");
    end

    // R9: refresh during and after an auto-precharge burst
    for (int k = 1; k <= 6; k++) begin
      do_reset();
      put(1'b1, CMD_ACT, 2'd0);
      put(1'b1, CMD_RDA, 2'd0);
      nops(k - 1);
      put(1'b1, CMD_REF, 2'd3);
      for (int i = 0; i < 3; i++) begin
        logic ev;
        ev = (k <= blh(i));
        chk(i, ev, ev ? 4'd1 : 4'd0, "R9 refresh sweep");
      end
    end
    do_reset();
    put(1'b1, CMD_ACT, 2'd3);
    put(1'b1, CMD_LMR, 2'd0);
    chk_all(1'b1, 4'd1, "R9 mode load busy");
    put(1'b1, CMD_PRE, 2'd3);
    put(1'b1, CMD_LMR, 2'd0);
    chk_all(1'b0, 4'd0, "R9 mode load idle");

    // R10: burst stop targeting
    do_reset();
    put(1'b1, CMD_ACT, 2'd0);
    put(1'b1, CMD_ACT, 2'd1);
    put(1'b1, CMD_RD, 2'd0);
    put(1'b1, CMD_BST, 2'd0);
    chk_all(1'b0, 4'd0, "R10 stop bursting bank");
    put(1'b1, CMD_BST, 2'd1);
    chk_all(1'b1, 4'd2, "R10 stop wrong bank");
    put(1'b1, CMD_BST, 2'd0);
    chk_all(1'b1, 4'd2, "R10 stop after end");
    put(1'b1, CMD_WR, 2'd1);
    chk_all(1'b0, 4'd0, "R10 stop lifts write block");
    do_reset();
    put(1'b1, CMD_ACT, 2'd0);
    put(1'b1, CMD_RDA, 2'd0);
    put(1'b1, CMD_BST, 2'd0);
    chk_all(1'b1, 4'd2, "R10 stop on ap burst");

    // R11: write after an unfinished plain read
    for (int k = 1; k <= 9; k++) begin
      do_reset();
      put(1'b1, CMD_ACT, 2'd0);
      put(1'b1, CMD_ACT, 2'd1);
      put(1'b1, CMD_RD, 2'd0);
      nops(k - 1);
      put(1'b1, CMD_WR, 2'd1);
      for (int i = 0; i < 3; i++) begin
        logic ev;
        ev = (k < clr() + blh(i));
        chk(i, ev, ev ? 4'd5 : 4'd0, "R11 read to write sweep");
      end
    end

    // R12: bank state rules
    do_reset();
    put(1'b1, CMD_ACT, 2'd0);
    put(1'b1, CMD_ACT, 2'd0);
    chk_all(1'b1, 4'd3, "R12 activate open bank");
    put(1'b1, CMD_RD, 2'd2);
    chk_all(1'b1, 4'd4, "R12 read idle bank");
    put(1'b1, CMD_RDA, 2'd0);
    put(1'b1, CMD_RD, 2'd0);
    chk_all(1'b1, 4'd4, "R12 read closing bank");
    put(1'b1, CMD_ACT, 2'd0);
    for (int i = 0; i < 3; i++) begin
      logic ev;
      ev = (2 <= blh(i));
      chk(i, ev, ev ? 4'd3 : 4'd0, "R12 activate closing bank");
    end

    // R3: flagged command leaves no trace, flag lasts one cycle
    do_reset();
    put(1'b1, CMD_ACT, 2'd1);
    put(1'b1, CMD_RD, 2'd2);
    chk_all(1'b1, 4'd4, "R3 flagged read");
    put(1'b1, CMD_NOP, 2'd0);
    chk_all(1'b0, 4'd0, "R3 one cycle flag");
    put(1'b1, CMD_WR, 2'd1);
    chk_all(1'b0, 4'd0, "R3 flagged read not applied");

    // R13: unknown code and priority
    do_reset();
    put(1'b1, 4'd12, 2'd0);
    chk_all(1'b1, 4'd10, "R13 unknown code");
    put(1'b1, CMD_ACT, 2'd0);
    put(1'b1, CMD_ACT, 2'd1);
    put(1'b1, CMD_ACT, 2'd2);
    put(1'b1, CMD_RD, 2'd2);
    put(1'b1, CMD_RDA, 2'd0);
    put(1'b1, CMD_WR, 2'd1);
    chk_all(1'b1, 4'd5, "R13 read block over spacing");
    put(1'b1, CMD_WR, 2'd3);
    chk_all(1'b1, 4'd4, "R13 not open over read block");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule